// File: doc/BRIEF.md
# No-Signal Vertical Timing Generator

This block keeps a liquid-crystal panel AC-driven when its video source goes away. It watches a vertical sync input and counts horizontal line pulses. The line pulses keep arriving during signal loss because the upstream PLL free-runs. If no vertical sync edge shows up within a line-count limit set by the video mode, the block enters a free-running state. In that state an auxiliary line counter times the vertical start pulse and the frame polarity output by itself.

While sync is present, every rising edge of the vertical sync input starts a frame. It issues the start pulse, flips the frame polarity and restarts both counters. The mode input picks the line period of the self-timed frame and the loss limit. A mode change applies only at a frame boundary, so no self-timed frame is ever cut short.

Top module: `vtg_nosig_tg`

## Requirements
- R1: After reset, `free_run_o`=1, `vst_o`=0 and `frp_o`=0. The auxiliary counter is at 0 and the active mode is code 0.
- R2: Mode codes are 0 = short standard (NTSC_LINES), 1 = long standard (PAL_LINES), and 2 or 3 = other (OTHER_LINES). In the free-running state, `vst_o` rises after the line pulse that completes each period of the active mode. The auxiliary counter runs from 0 to period−1.
- R3: `vst_o` is cleared by the next line pulse that does not itself start a frame, so it lasts at most one line.
- R4: `frp_o` toggles in exactly the cycle in which `vst_o` is set for a new frame, both with sync present and in the free-running state.
- R5: `free_run_o` rises after the line pulse that ends a run of lines with no sync rising edge. The run is SHORT_TIMEOUT lines when the active mode is 0 and LONG_TIMEOUT lines otherwise.
- R6: A rising edge on `vsync_i` does the following in the next cycle: clears `free_run_o`, sets `vst_o`, toggles `frp_o`, restarts the loss and auxiliary counts, and loads the active mode from `mode_i`.
- R7: `vsync_i` held high with no new rising edge has no effect. The loss timeout still expires.
- R8: A new `mode_i` value takes effect only at the next auxiliary counter wrap or sync rising edge.
- R9: With sync present (`free_run_o`=0), auxiliary counter wraps produce no `vst_o` and no `frp_o` change.
- R10: Sync edges that arrive within the loss limit keep `free_run_o` low indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_pulse_i | input | 1 | One-cycle pulse per horizontal line |
| vsync_i | input | 1 | Vertical sync, rising edge is the event |
| mode_i | input | 2 | Video mode select |
| vst_o | output | 1 | Vertical start pulse |
| frp_o | output | 1 | Frame polarity |
| free_run_o | output | 1 | High while in the free-running state |

## Verification
Every output is a register. A line pulse or sync edge sampled at one rising edge therefore shows at the ports right after that same edge, one cycle of latency. The bench drives stimulus on falling edges and compares on the falling edge after the stimulus task ends, well after the update. Expected frame boundaries, timeout lines and polarity are worked out arithmetically from the line index since the last sync edge or mode switch. This is done with small period and timeout values so that every line of several frames is compared.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  typedef enum logic [1:0] {
    MODE_SHORT = 2'd0,
    MODE_LONG  = 2'd1,
    MODE_OTH_A = 2'd2,
    MODE_OTH_B = 2'd3
  } vtg_mode_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/vtg_edge.sv
module vtg_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/vtg_aux_cnt.sv
module vtg_aux_cnt
  import vtg_pkg::*;
#(
  parameter int unsigned SHORT_LINES = 263,
  parameter int unsigned LONG_LINES  = 313,
  parameter int unsigned OTHER_LINES = 650,
  parameter int unsigned CNT_W       = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  input  logic             restart_i,
  input  logic [1:0]       mode_i,
  output vtg_mode_e        act_mode_o,
  output logic             wrap_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] len_o
);
  localparam int unsigned NUM_MODES = 4;

  logic [CNT_W-1:0] len_tab [NUM_MODES];

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_len
    localparam int unsigned LEN = (g == 0) ? SHORT_LINES :
                                  (g == 1) ? LONG_LINES  : OTHER_LINES;
    assign len_tab[g] = CNT_W'(LEN);
  end

  assign len_o  = len_tab[act_mode_o];
  assign wrap_o = line_i && (cnt_o == len_o - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o      <= '0;
      act_mode_o <= MODE_SHORT;
    end else if (restart_i) begin
      cnt_o      <= '0;
      act_mode_o <= vtg_mode_e'(mode_i);
    end else if (wrap_o) begin
      cnt_o      <= '0;
      act_mode_o <= vtg_mode_e'(mode_i);
    end else if (line_i) begin
      cnt_o      <= cnt_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/vtg_loss_det.sv
module vtg_loss_det #(
  parameter int unsigned SHORT_TIMEOUT = 468,
  parameter int unsigned LONG_TIMEOUT  = 900,
  parameter int unsigned CNT_W         = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic restart_i,
  input  logic long_i,
  output logic free_run_o
);
  logic [CNT_W-1:0] loss_cnt;
  logic [CNT_W-1:0] limit;

  assign limit = long_i ? CNT_W'(LONG_TIMEOUT - 1) : CNT_W'(SHORT_TIMEOUT - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loss_cnt   <= '0;
      free_run_o <= 1'b1;
    end else if (restart_i) begin
      loss_cnt   <= '0;
      free_run_o <= 1'b0;
    end else if (line_i && !free_run_o) begin
      if (loss_cnt >= limit) begin
        loss_cnt   <= '0;
        free_run_o <= 1'b1;
      end else begin
        loss_cnt   <= loss_cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/vtg_pulse_gen.sv
module vtg_pulse_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic fire_i,
  output logic vst_o,
  output logic frp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vst_o <= 1'b0;
      frp_o <= 1'b0;
    end else if (fire_i) begin
      vst_o <= 1'b1;
      frp_o <= ~frp_o;
    end else if (line_i) begin
      vst_o <= 1'b0;
    end
  end
endmodule

// File: rtl/vtg_nosig_tg.sv
module vtg_nosig_tg
  import vtg_pkg::*;
#(
  parameter int unsigned SHORT_LINES   = 263,
  parameter int unsigned LONG_LINES    = 313,
  parameter int unsigned OTHER_LINES   = 650,
  parameter int unsigned SHORT_TIMEOUT = 468,
  parameter int unsigned LONG_TIMEOUT  = 900
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_pulse_i,
  input  logic       vsync_i,
  input  logic [1:0] mode_i,
  output logic       vst_o,
  output logic       frp_o,
  output logic       free_run_o
);
  localparam int unsigned MAX_LINES =
    max_u(max_u(max_u(SHORT_LINES, LONG_LINES), OTHER_LINES),
          max_u(SHORT_TIMEOUT, LONG_TIMEOUT));
  localparam int unsigned CNT_W = $clog2(MAX_LINES + 1);

  logic             vs_rise;
  logic             aux_wrap;
  logic [CNT_W-1:0] aux_cnt;
  logic [CNT_W-1:0] aux_len;
  vtg_mode_e        act_mode;
  logic             fire;

  vtg_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (vsync_i),
    .rise_o (vs_rise)
  );

  vtg_aux_cnt #(
    .SHORT_LINES (SHORT_LINES),
    .LONG_LINES  (LONG_LINES),
    .OTHER_LINES (OTHER_LINES),
    .CNT_W       (CNT_W)
  ) u_aux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_i     (line_pulse_i),
    .restart_i  (vs_rise),
    .mode_i     (mode_i),
    .act_mode_o (act_mode),
    .wrap_o     (aux_wrap),
    .cnt_o      (aux_cnt),
    .len_o      (aux_len)
  );

  vtg_loss_det #(
    .SHORT_TIMEOUT (SHORT_TIMEOUT),
    .LONG_TIMEOUT  (LONG_TIMEOUT),
    .CNT_W         (CNT_W)
  ) u_loss (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_i     (line_pulse_i),
    .restart_i  (vs_rise),
    .long_i     (act_mode != MODE_SHORT),
    .free_run_o (free_run_o)
  );

  // frame start: sync edge, or self-timed wrap while free-running
  assign fire = vs_rise | (free_run_o & aux_wrap);

  vtg_pulse_gen u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_pulse_i),
    .fire_i (fire),
    .vst_o  (vst_o),
    .frp_o  (frp_o)
  );
endmodule

module vtg_nosig_tg_chk #(
  parameter int unsigned CNT_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             line_pulse_i,
  input logic             vst_o,
  input logic             frp_o,
  input logic             free_run_o,
  input logic             vs_rise,
  input logic             aux_wrap,
  input logic [CNT_W-1:0] aux_cnt,
  input logic [CNT_W-1:0] aux_len
);
  p_aux_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_cnt < aux_len);

  p_vst_one_line_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vst_o && line_pulse_i && !vs_rise && !(free_run_o && aux_wrap)) |=> !vst_o);

  p_frp_with_vst_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frp_o != $past(frp_o)) |-> vst_o);

  p_free_run_on_line_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(free_run_o) |-> $past(line_pulse_i));

  p_sync_resumes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_rise |=> (!free_run_o && vst_o));

  p_no_normal_vst_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vst_o) |-> $past(vs_rise || (free_run_o && aux_wrap)));
endmodule

bind vtg_nosig_tg vtg_nosig_tg_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .line_pulse_i (line_pulse_i),
  .vst_o        (vst_o),
  .frp_o        (frp_o),
  .free_run_o   (free_run_o),
  .vs_rise      (vs_rise),
  .aux_wrap     (aux_wrap),
  .aux_cnt      (aux_cnt),
  .aux_len      (aux_len)
);

// File: tb/vtg_nosig_tg_test.sv
module vtg_nosig_tg_test;
  localparam int unsigned NS = 5;
  localparam int unsigned NL = 7;
  localparam int unsigned NO = 11;
  localparam int unsigned TS = 9;
  localparam int unsigned TL = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_pulse = 1'b0;
  logic       vsync = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       vst, frp, free_run;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  logic exp_frp = 1'b0;

  always #5 clk = ~clk;

  vtg_nosig_tg #(
    .SHORT_LINES (NS), .LONG_LINES (NL), .OTHER_LINES (NO),
    .SHORT_TIMEOUT (TS), .LONG_TIMEOUT (TL)
  ) uut (
    .clk_i (clk), .rst_ni (rst_n), .line_pulse_i (line_pulse),
    .vsync_i (vsync), .mode_i (mode),
    .vst_o (vst), .frp_o (frp), .free_run_o (free_run)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic line();
    @(negedge clk); line_pulse = 1'b1;
    @(negedge clk); line_pulse = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic vs_pulse();
    @(negedge clk); vsync = 1'b1;
    @(negedge clk); vsync = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_frame(input string tag, input logic exp_vst, input logic exp_fr);
    if (exp_vst) exp_frp = ~exp_frp;
    chk({tag, " vst"}, vst, exp_vst);
    chk("R4 frp", frp, exp_frp);
    chk("R5 free_run", free_run, exp_fr);
  endtask

  task automatic chk_sync_edge();
    exp_frp = ~exp_frp;
    chk("R6 free_run cleared", free_run, 1'b0);
    chk("R6 vst set", vst, 1'b1);
    chk("R6 frp toggled", frp, exp_frp);
  endtask

  // sync edge, then n lines; free-run after tmo lines, frames of period p
  task automatic loss_run(input logic [1:0] m, input int tmo, input int p, input int n);
    mode = m;
    vs_pulse();
    chk_sync_edge();
    for (int j = 1; j <= n; j++) begin
      line();
      chk_frame("R2/R9", (j > tmo) && (j % p == 0), j >= tmo);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 vst", vst, 1'b0);
    chk("R1 frp", frp, 1'b0);
    chk("R1 free_run", free_run, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 free_run after release", free_run, 1'b1);

    // R1/R2: free-run from reset, active mode 0, period NS
    for (int k = 1; k <= 22; k++) begin
      line();
      chk_frame("R2", (k % NS) == 0, 1'b1);
    end
    // R8: switch to mode 1 mid-frame; applies at wrap k=25
    mode = 2'd1;
    for (int k = 23; k <= 46; k++) begin
      line();
      chk_frame("R8", (k <= 25) ? (k % NS == 0) : ((k - 25) % NL == 0), 1'b1);
    end

    // R6/R9/R3/R5: sync edge in mode 1, long timeout
    loss_run(2'd1, TL, NL, 22);
    // R5: mode 0, short timeout
    loss_run(2'd0, TS, NS, 12);
    // R2: other modes 2 and 3
    loss_run(2'd2, TL, NO, 35);
    loss_run(2'd3, TL, NO, 23);

    // R10: sync every 8 lines in mode 0 keeps free_run low, wraps silent (R9)
    mode = 2'd0;
    for (int f = 0; f < 6; f++) begin
      vs_pulse();
      chk_sync_edge();
      for (int j = 1; j <= 8; j++) begin
        line();
        chk_frame("R10", 1'b0, 1'b0);
      end
    end

    // R7: vsync held high, only one edge
    @(negedge clk); vsync = 1'b1;
    @(negedge clk);
    chk_sync_edge();
    for (int j = 1; j <= 12; j++) begin
      line();
      chk_frame("R7", (j > TS) && (j % NS == 0), j >= TS);
    end
    @(negedge clk); vsync = 1'b0;
    @(negedge clk);
    chk("R7 falling edge ignored", free_run, 1'b1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule